// File: doc/BRIEF.md
# Paged Memory Address Decoder

This block turns a 16-bit processor address and its memory strobes into the chip selects, output enable and gated write strobes for four kinds of storage. These are a 32K boot/extended ROM, a 32K system RAM, and a 128K RAM disk reached through a 16K window at the top of the address space. A decode happens whenever a memory request or a refresh cycle is active. Video pattern fetches made during refresh therefore reach memory in the same way as ordinary accesses.

A shadow switch lets a new operating system be tried from RAM. When the switch is closed, the RAM segment that normally sits at 32–40K answers at 0–8K and cannot be written there. The boot ROM image moves up to 32–40K. Both memories use the low address lines unchanged, so the swap only steers chip selects.

The top 16K window holds either one of eight RAM-disk pages, chosen by three page bits, or a single page of ROM disk, chosen by a mode bit. Writes to the RAM disk can be blocked by a port bit or by a manual switch.

Top module: `mem_mapper`

## Requirements
- R1: With both `mreq_n` and `rfsh_n` high, every chip select, the ROM output enable and both write strobes are high (inactive).
- R2: With `shadow_on`=0, addresses 0x0000–0x1FFF and 0xA000–0xBFFF select the ROM (`rom_cs_n`=0), and 0x2000–0x9FFF select the RAM (`ram_cs_n`=0).
- R3: With `shadow_on`=1, 0x0000–0x7FFF selects the RAM, 0x8000–0x9FFF selects the ROM, and 0xA000–0xBFFF still selects the ROM.
- R4: With `shadow_on`=1, a write to 0x0000–0x1FFF leaves `ram_we_n` high, while writes to 0x2000–0x7FFF drive it low.
- R5: A refresh cycle alone (`rfsh_n`=0, `mreq_n`=1) decodes like a memory request, and a ROM hit then drives `rom_oe_n` low.
- R6: In the window 0xC000–0xFFFF with `disk_ram_en`=1, `disk_cs_n` is low and both `rom_cs_n` and `rom_oe_n` are high.
- R7: In the window with `disk_ram_en`=0, the ROM is selected (`rom_cs_n`=0) and `disk_cs_n` stays high.
- R8: `disk_addr_hi[2:0]` equals the three page bits `disk_page[2:0]`.
- R9: `disk_we_n` goes low only for a write (`wr_n`=0) to the selected RAM disk with `disk_wp_port`=0 and `disk_wp_sw`=0; either protect input at 1 holds it high.
- R10: For any address and mode, at most one of `rom_cs_n`, `ram_cs_n` and `disk_cs_n` is low.
- R11: `rom_oe_n` is low only while the ROM is selected and either `rd_n` or `rfsh_n` is low.
- R12: `ram_we_n` is low only for a write to a selected, unprotected RAM address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| rfsh_n | input | 1 | Refresh cycle, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| shadow_on | input | 1 | Swap the 32–40K RAM into the boot area |
| disk_page | input | 3 | RAM-disk page number |
| disk_ram_en | input | 1 | 1 = RAM disk in the top window, 0 = ROM disk page |
| disk_wp_port | input | 1 | Software write protect for the RAM disk |
| disk_wp_sw | input | 1 | Manual write protect for the RAM disk |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| ram_cs_n | output | 1 | System RAM chip select, active low |
| ram_we_n | output | 1 | Gated RAM write, active low |
| disk_cs_n | output | 1 | RAM-disk chip select, active low |
| disk_we_n | output | 1 | Gated RAM-disk write, active low |
| disk_addr_hi | output | 3 | Upper RAM-disk address bits |

## Verification
Every output is a pure function of the present inputs and holds no register. Each result is therefore due in the same cycle as its stimulus, with zero clock latency. The bench drives a new input set just after a rising clock edge and samples all outputs at the following falling edge, half a period later, when the decode has settled. The same applies to the vector table, the address sweeps and the page sweep, so no check straddles an input change.

// File: rtl/mem_mapper.sv
module mem_mapper #(
  parameter int PAGE_W = 3
) (
  input  logic [15:0]       addr,
  input  logic              mreq_n,
  input  logic              rfsh_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              shadow_on,
  input  logic [PAGE_W-1:0] disk_page,
  input  logic              disk_ram_en,
  input  logic              disk_wp_port,
  input  logic              disk_wp_sw,
  output logic              rom_cs_n,
  output logic              rom_oe_n,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              disk_cs_n,
  output logic              disk_we_n,
  output logic [PAGE_W-1:0] disk_addr_hi
);

  logic [2:0] seg;
  logic       en, in_boot, in_low_ram, in_swap, in_ext, in_win;
  logic       rom_hit, ram_hit, disk_hit;

  assign seg        = addr[15:13];
  assign en         = ~mreq_n | ~rfsh_n;
  assign in_boot    = (seg == 3'd0);
  assign in_low_ram = (seg == 3'd1) | (seg == 3'd2) | (seg == 3'd3);
  assign in_swap    = (seg == 3'd4);
  assign in_ext     = (seg == 3'd5);
  assign in_win     = (seg[2:1] == 2'b11);

  assign rom_hit  = en & ((in_boot & ~shadow_on) | (in_swap & shadow_on) |
                          in_ext | (in_win & ~disk_ram_en));
  assign ram_hit  = en & ((in_boot & shadow_on) | in_low_ram |
                          (in_swap & ~shadow_on));
  assign disk_hit = en & in_win & disk_ram_en;

  assign rom_cs_n  = ~rom_hit;
  assign rom_oe_n  = ~(rom_hit & (~rd_n | ~rfsh_n));
  assign ram_cs_n  = ~ram_hit;
  assign ram_we_n  = ~(ram_hit & ~wr_n & ~(shadow_on & in_boot));
  assign disk_cs_n = ~disk_hit;
  assign disk_we_n = ~(disk_hit & ~wr_n & ~disk_wp_port & ~disk_wp_sw);
  assign disk_addr_hi = disk_page;

endmodule

// File: rtl/mem_mapper_chk.sv
module mem_mapper_chk (
  input logic [15:0] addr,
  input logic        mreq_n,
  input logic        rfsh_n,
  input logic        rd_n,
  input logic        shadow_on,
  input logic        disk_wp_port,
  input logic        disk_wp_sw,
  input logic        rom_cs_n,
  input logic        rom_oe_n,
  input logic        ram_cs_n,
  input logic        ram_we_n,
  input logic        disk_cs_n,
  input logic        disk_we_n
);

  always_comb begin
    if (mreq_n && rfsh_n)
      p_idle_quiet_r1: assert (rom_cs_n && ram_cs_n && disk_cs_n && ram_we_n && disk_we_n && rom_oe_n)
        else $error("idle strobes but memory active");
    p_single_select_r10: assert ($onehot0({~rom_cs_n, ~ram_cs_n, ~disk_cs_n}))
      else $error("more than one chip select");
    if (!rom_oe_n)
      p_oe_qualified_r11: assert (!rom_cs_n && (!rd_n || !rfsh_n))
        else $error("ROM output enable without select or read");
    if (shadow_on && addr[15:13] == 3'd0)
      p_shadow_protect_r4: assert (ram_we_n)
        else $error("write reached shadowed boot RAM");
    if (disk_wp_port || disk_wp_sw)
      p_disk_protect_r9: assert (disk_we_n)
        else $error("write reached protected RAM disk");
    if (!disk_cs_n)
      p_disk_window_r6: assert (addr[15:14] == 2'b11 && rom_oe_n)
        else $error("RAM disk outside window or ROM driving");
    if (!ram_we_n)
      p_ram_write_sel_r12: assert (!ram_cs_n)
        else $error("RAM write without select");
  end

endmodule

bind mem_mapper mem_mapper_chk u_chk (
  .addr(addr), .mreq_n(mreq_n), .rfsh_n(rfsh_n), .rd_n(rd_n),
  .shadow_on(shadow_on), .disk_wp_port(disk_wp_port), .disk_wp_sw(disk_wp_sw),
  .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .ram_cs_n(ram_cs_n),
  .ram_we_n(ram_we_n), .disk_cs_n(disk_cs_n), .disk_we_n(disk_we_n)
);

// File: tb/sim_mem_mapper.sv
module sim_mem_mapper;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] addr;
  logic mreq_n, rfsh_n, rd_n, wr_n, shadow_on, disk_ram_en, disk_wp_port, disk_wp_sw;
  logic [2:0] disk_page;
  logic rom_cs_n, rom_oe_n, ram_cs_n, ram_we_n, disk_cs_n, disk_we_n;
  logic [2:0] disk_addr_hi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  mem_mapper u0 (
    .addr(addr), .mreq_n(mreq_n), .rfsh_n(rfsh_n), .rd_n(rd_n), .wr_n(wr_n),
    .shadow_on(shadow_on), .disk_page(disk_page), .disk_ram_en(disk_ram_en),
    .disk_wp_port(disk_wp_port), .disk_wp_sw(disk_wp_sw),
    .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .ram_cs_n(ram_cs_n),
    .ram_we_n(ram_we_n), .disk_cs_n(disk_cs_n), .disk_we_n(disk_we_n),
    .disk_addr_hi(disk_addr_hi)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [15:0] a;
    logic mq, rf, rd, wr, sh, re;
    logic [2:0] pg;
    logic wp, ws;
    logic rcs, roe, ram, rwe, dcs, dwe;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  16'h0100, 0,1,0,1, 0,1, 3'd0, 0,0,  0,0,1,1,1,1}, // R2 boot ROM
    '{8'd2,  16'h2000, 0,1,0,1, 0,1, 3'd0, 0,0,  1,1,0,1,1,1}, // R2 RAM
    '{8'd12, 16'h4000, 0,1,1,0, 0,1, 3'd0, 0,0,  1,1,0,0,1,1}, // R12 RAM write
    '{8'd2,  16'hA000, 0,1,0,1, 0,1, 3'd0, 0,0,  0,0,1,1,1,1}, // R2 ext ROM
    '{8'd2,  16'h8000, 0,1,0,1, 0,1, 3'd0, 0,0,  1,1,0,1,1,1}, // R2 32K RAM
    '{8'd3,  16'h0100, 0,1,0,1, 1,1, 3'd0, 0,0,  1,1,0,1,1,1}, // R3 shadow RAM low
    '{8'd3,  16'h8100, 0,1,0,1, 1,1, 3'd0, 0,0,  0,0,1,1,1,1}, // R3 ROM moved up
    '{8'd4,  16'h0100, 0,1,1,0, 1,1, 3'd0, 0,0,  1,1,0,1,1,1}, // R4 blocked write
    '{8'd4,  16'h2000, 0,1,1,0, 1,1, 3'd0, 0,0,  1,1,0,0,1,1}, // R4 open write
    '{8'd5,  16'h1E00, 1,0,1,1, 0,1, 3'd0, 0,0,  0,0,1,1,1,1}, // R5 refresh fetch
    '{8'd1,  16'h4000, 1,1,0,0, 0,1, 3'd0, 0,0,  1,1,1,1,1,1}, // R1 no strobe
    '{8'd6,  16'hC000, 0,1,0,1, 0,1, 3'd5, 0,0,  1,1,1,1,0,1}, // R6 RAM disk
    '{8'd7,  16'hE000, 0,1,0,1, 0,0, 3'd5, 0,0,  0,0,1,1,1,1}, // R7 ROM disk
    '{8'd9,  16'hC000, 0,1,1,0, 0,1, 3'd2, 0,0,  1,1,1,1,0,0}, // R9 open disk write
    '{8'd9,  16'hC000, 0,1,1,0, 0,1, 3'd2, 1,0,  1,1,1,1,0,1}, // R9 port protect
    '{8'd9,  16'hFFFF, 0,1,1,0, 0,1, 3'd2, 0,1,  1,1,1,1,0,1}, // R9 switch protect
    '{8'd11, 16'hA000, 0,1,1,1, 0,1, 3'd0, 0,0,  0,1,1,1,1,1}, // R11 no read
    '{8'd7,  16'hE000, 0,1,1,0, 0,0, 3'd0, 0,0,  0,1,1,1,1,1}  // R7 write to ROM disk
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    addr = v.a; mreq_n = v.mq; rfsh_n = v.rf; rd_n = v.rd; wr_n = v.wr;
    shadow_on = v.sh; disk_ram_en = v.re; disk_page = v.pg;
    disk_wp_port = v.wp; disk_wp_sw = v.ws;
  endtask

  function automatic logic [15:0] outs();
    return {10'd0, rom_cs_n, rom_oe_n, ram_cs_n, ram_we_n, disk_cs_n, disk_we_n};
  endfunction

  initial begin
    addr = 16'h0; mreq_n = 1; rfsh_n = 1; rd_n = 1; wr_n = 1;
    shadow_on = 0; disk_ram_en = 1; disk_page = 3'd0; disk_wp_port = 0; disk_wp_sw = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle state", outs(), 16'h003F);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      drive(VEC[i]);
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), outs(),
          {10'd0, VEC[i].rcs, VEC[i].roe, VEC[i].ram, VEC[i].rwe, VEC[i].dcs, VEC[i].dwe});
    end

    // R10: one select per address, every mode
    rd_n = 0; wr_n = 1; mreq_n = 0; rfsh_n = 1;
    for (int sh = 0; sh < 2; sh++)
      for (int re = 0; re < 2; re++)
        for (int k = 0; k < 64; k++) begin
          @(posedge clk);
          shadow_on = sh[0]; disk_ram_en = re[0]; addr = 16'(k * 1024);
          @(negedge clk);
          chk("R10 select count", 16'($countones({~rom_cs_n, ~ram_cs_n, ~disk_cs_n})), 16'd1);
        end

    // R8: page bits reach the disk address
    for (int p = 0; p < 8; p++) begin
      @(posedge clk);
      disk_page = 3'(p); addr = 16'hD000;
      @(negedge clk);
      chk("R8 page bits", {13'd0, disk_addr_hi}, 16'(p));
    end

    // R1: strobes released while addressing the disk window
    @(posedge clk);
    mreq_n = 1; rfsh_n = 1; wr_n = 0; addr = 16'hC000; disk_ram_en = 1;
    @(negedge clk);
    chk("R1 released strobes", outs(), 16'h003F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule